// File: doc/BRIEF.md
# Fused-Micro-Op Integer ALU

This block is the combinational integer arithmetic unit of a 64-bit RISC-V execution pipe. It takes two 64-bit operands and a 7-bit operation code, and returns one 64-bit result in the same cycle. It covers the ordinary add, subtract, compare, logic and shift operations and their word forms. It also runs internal micro-ops that the decoder creates when it merges two adjacent instructions into one. These cover shift-then-add, zero-extend-then-shift, byte extraction, low-bit masking and upper-bit merging. The two conditional-zero operations complete the set.

Word forms go through a separate 32-bit adder. That adder's carry chain stays short, and its sign-extended result then passes through an optional low-bit mask. The 64-bit adder has a small pre-shifter on its first operand, which serves the fused shift-add forms. Shifts and logic each have their own unit. A one-hot group select picks the unit whose result goes to the output. A code that belongs to no group drives zero.

Top module: `fualu_top`

## Requirements
- R1: The operation code is 7 bits wide. Any code not listed in R2 to R12 gives a result of zero.
- R2: Codes 0x00 ADD, 0x01 SUB, 0x02 SLT (signed, result 1 or 0), 0x03 SLTU (unsigned, result 1 or 0), 0x04 AND, 0x05 OR and 0x06 XOR work on the full 64 bits. Sums wrap modulo 2^64.
- R3: Codes 0x07 SLL, 0x08 SRL and 0x09 SRA shift operand 1 by operand 2 bits [5:0]. Codes 0x42 SLLW, 0x43 SRLW and 0x44 SRAW shift the low word of operand 1 by operand 2 bits [4:0], then sign-extend bit 31 of that result.
- R4: Codes 0x40 ADDW and 0x41 SUBW add or subtract the low 32 bits of the operands, then sign-extend bit 31 of the 32-bit result to 64 bits.
- R5: Code 0x24 gives zero when operand 2 is zero and operand 1 otherwise. Code 0x25 gives zero when operand 2 is nonzero and operand 1 otherwise.
- R6: Code 0x10 gives (op1 << 4) + op2. Codes 0x11, 0x12, 0x13 and 0x14 give (op1 >> n) + op2, where the shift is logical and n is 29, 30, 31 and 32 in that order.
- R7: Code 0x15 gives (op1 & 1) + op2 over 64 bits. Code 0x45 adds op1 bit 0 to the low word of op2 and sign-extends bit 31 of the sum.
- R8: Codes 0x18, 0x19 and 0x1A take the zero-extended low 32 bits of operand 1 and shift them left by 1, 2 and 3 in that order.
- R9: Code 0x1B gives operand 1 bits [15:8] in result bits [7:0], with all upper bits zero.
- R10: Code 0x20 gives (op1 with bits [7:0] cleared) OR op2.
- R11: Codes 0x46 and 0x47 form the sign-extended word sum of the operands. Code 0x46 then keeps only bits [7:0] and code 0x47 keeps only bit 0, with all other bits zero.
- R12: Codes 0x21, 0x22 and 0x23 give bit 0 of op1 AND, OR and XOR op2 respectively, with result bits [63:1] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 7 | Operation code |
| src1_i | input | 64 | Operand 1 |
| src2_i | input | 64 | Operand 2 |
| res_o | output | 64 | Result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the operand ports and the result port. The bench changes the operands and the code just after a rising clock edge. It then compares the result at the following falling edge, half a period later, against a behavioural model. The stimulus covers all 128 codes. For each code it uses a grid of corner operands (zero, all ones, the word sign bit, the largest positive word, one) and then random operands. So each micro-op meets its wrap, sign-extension and masking edges, and every unused code is shown to give zero.

// File: rtl/fualu_pkg.sv
package fualu_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = 32;
  localparam int OPW  = 7;
  localparam int NGRP = 4;
  localparam int GI_ADD  = 0;
  localparam int GI_ADDW = 1;
  localparam int GI_SHF  = 2;
  localparam int GI_LOG  = 3;

  typedef logic [OPW-1:0] opc_t;

  localparam opc_t OP_ADD      = 7'h00;
  localparam opc_t OP_SUB      = 7'h01;
  localparam opc_t OP_SLT      = 7'h02;
  localparam opc_t OP_SLTU     = 7'h03;
  localparam opc_t OP_AND      = 7'h04;
  localparam opc_t OP_OR       = 7'h05;
  localparam opc_t OP_XOR      = 7'h06;
  localparam opc_t OP_SLL      = 7'h07;
  localparam opc_t OP_SRL      = 7'h08;
  localparam opc_t OP_SRA      = 7'h09;
  localparam opc_t OP_SH4ADD   = 7'h10;
  localparam opc_t OP_SR29ADD  = 7'h11;
  localparam opc_t OP_SR30ADD  = 7'h12;
  localparam opc_t OP_SR31ADD  = 7'h13;
  localparam opc_t OP_SR32ADD  = 7'h14;
  localparam opc_t OP_ODDADD   = 7'h15;
  localparam opc_t OP_SZEWL1   = 7'h18;
  localparam opc_t OP_SZEWL2   = 7'h19;
  localparam opc_t OP_SZEWL3   = 7'h1A;
  localparam opc_t OP_BYTE2    = 7'h1B;
  localparam opc_t OP_ORH48    = 7'h20;
  localparam opc_t OP_ANDLSB   = 7'h21;
  localparam opc_t OP_ORLSB    = 7'h22;
  localparam opc_t OP_XORLSB   = 7'h23;
  localparam opc_t OP_CZEQZ    = 7'h24;
  localparam opc_t OP_CZNEZ    = 7'h25;
  localparam opc_t OP_ADDW     = 7'h40;
  localparam opc_t OP_SUBW     = 7'h41;
  localparam opc_t OP_SLLW     = 7'h42;
  localparam opc_t OP_SRLW     = 7'h43;
  localparam opc_t OP_SRAW     = 7'h44;
  localparam opc_t OP_ODDADDW  = 7'h45;
  localparam opc_t OP_ADDWBYTE = 7'h46;
  localparam opc_t OP_ADDWBIT  = 7'h47;

  // Widen a word to the full register width by copying its top bit.
  function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
    return {{(XLEN-WLEN){w[WLEN-1]}}, w};
  endfunction

  // One-hot selection of the unit that owns an operation code.
  function automatic logic [NGRP-1:0] op_group(input opc_t op);
    logic [NGRP-1:0] g;
    g = '0;
    case (op)
      OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_SH4ADD, OP_SR29ADD,
      OP_SR30ADD, OP_SR31ADD, OP_SR32ADD, OP_ODDADD:          g[GI_ADD]  = 1'b1;
      OP_ADDW, OP_SUBW, OP_ODDADDW, OP_ADDWBYTE, OP_ADDWBIT:  g[GI_ADDW] = 1'b1;
      OP_SLL, OP_SRL, OP_SRA, OP_SLLW, OP_SRLW, OP_SRAW,
      OP_SZEWL1, OP_SZEWL2, OP_SZEWL3, OP_BYTE2:              g[GI_SHF]  = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_ANDLSB, OP_ORLSB, OP_XORLSB,
      OP_ORH48, OP_CZEQZ, OP_CZNEZ:                           g[GI_LOG]  = 1'b1;
      default:                                                g          = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/fualu_add64.sv
module fualu_add64 import fualu_pkg::*; #(
  parameter int XW = XLEN
) (
  input  opc_t          op_i,
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  output logic [XW-1:0] res_o
);
  logic [XW-1:0] pre_a;
  logic [XW-1:0] b_eff;
  logic          inv;
  logic [XW:0]   sum_w;
  logic          lt_s;
  logic          lt_u;

  // First-operand pre-shifter for the fused shift-add forms.
  always_comb begin
    pre_a = a_i;
    inv   = 1'b0;
    case (op_i)
      OP_SUB, OP_SLT, OP_SLTU: inv   = 1'b1;
      OP_SH4ADD:               pre_a = a_i << 4;
      OP_SR29ADD:              pre_a = a_i >> 29;
      OP_SR30ADD:              pre_a = a_i >> 30;
      OP_SR31ADD:              pre_a = a_i >> 31;
      OP_SR32ADD:              pre_a = a_i >> 32;
      OP_ODDADD:               pre_a = {{(XW-1){1'b0}}, a_i[0]};
      default:                 pre_a = a_i;
    endcase
  end

  assign b_eff = inv ? ~b_i : b_i;
  assign sum_w = {1'b0, pre_a} + {1'b0, b_eff} + {{XW{1'b0}}, inv};
  // No carry out of a + ~b + 1 means a < b unsigned.
  assign lt_u  = ~sum_w[XW];
  assign lt_s  = (a_i[XW-1] ^ b_i[XW-1]) ? a_i[XW-1] : sum_w[XW-1];

  always_comb begin
    case (op_i)
      OP_SLT:  res_o = {{(XW-1){1'b0}}, lt_s};
      OP_SLTU: res_o = {{(XW-1){1'b0}}, lt_u};
      default: res_o = sum_w[XW-1:0];
    endcase
  end
endmodule

// File: rtl/fualu_addw.sv
module fualu_addw import fualu_pkg::*; #(
  parameter int XW = XLEN,
  parameter int WW = WLEN
) (
  input  opc_t          op_i,
  input  logic [WW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  output logic [XW-1:0] res_o
);
  logic [WW-1:0] pre_a;
  logic          inv;
  logic [WW-1:0] sum_w;
  logic [XW-1:0] ext;

  always_comb begin
    pre_a = a_i;
    inv   = 1'b0;
    case (op_i)
      OP_SUBW:    inv   = 1'b1;
      OP_ODDADDW: pre_a = {{(WW-1){1'b0}}, a_i[0]};
      default:    pre_a = a_i;
    endcase
  end

  // Short carry chain: only the low word is summed.
  assign sum_w = pre_a + (inv ? ~b_i : b_i) + {{(WW-1){1'b0}}, inv};
  assign ext   = {{(XW-WW){sum_w[WW-1]}}, sum_w};

  always_comb begin
    case (op_i)
      OP_ADDWBYTE: res_o = {{(XW-8){1'b0}}, ext[7:0]};
      OP_ADDWBIT:  res_o = {{(XW-1){1'b0}}, ext[0]};
      default:     res_o = ext;
    endcase
  end
endmodule

// File: rtl/fualu_shift.sv
module fualu_shift import fualu_pkg::*; #(
  parameter int XW = XLEN,
  parameter int WW = WLEN,
  parameter int NZW = 3
) (
  input  opc_t                  op_i,
  input  logic [XW-1:0]         a_i,
  input  logic [$clog2(XW)-1:0] sh_i,
  output logic [XW-1:0]         res_o
);
  localparam int SWW = $clog2(WW);

  logic [SWW-1:0] shw;
  logic [WW-1:0]  sllw_r;
  logic [WW-1:0]  srlw_r;
  logic [WW-1:0]  sraw_r;
  logic [XW-1:0]  zw [NZW];

  assign shw    = sh_i[SWW-1:0];
  assign sllw_r = a_i[WW-1:0] << shw;
  assign srlw_r = a_i[WW-1:0] >> shw;
  assign sraw_r = $unsigned($signed(a_i[WW-1:0]) >>> shw);

  // Zero-extended low word shifted left by 1..NZW.
  for (genvar k = 0; k < NZW; k++) begin : g_zw
    assign zw[k] = {{(XW-WW){1'b0}}, a_i[WW-1:0]} << (k + 1);
  end

  always_comb begin
    case (op_i)
      OP_SLL:    res_o = a_i << sh_i;
      OP_SRL:    res_o = a_i >> sh_i;
      OP_SRA:    res_o = $unsigned($signed(a_i) >>> sh_i);
      OP_SLLW:   res_o = sext_word(sllw_r);
      OP_SRLW:   res_o = sext_word(srlw_r);
      OP_SRAW:   res_o = sext_word(sraw_r);
      OP_SZEWL1: res_o = zw[0];
      OP_SZEWL2: res_o = zw[1];
      OP_SZEWL3: res_o = zw[2];
      OP_BYTE2:  res_o = {{(XW-8){1'b0}}, a_i[15:8]};
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/fualu_logic.sv
module fualu_logic import fualu_pkg::*; #(
  parameter int XW = XLEN
) (
  input  opc_t          op_i,
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  output logic [XW-1:0] res_o
);
  logic          b_zero;
  logic [XW-1:0] and_r;
  logic [XW-1:0] or_r;
  logic [XW-1:0] xor_r;

  assign b_zero = (b_i == '0);
  assign and_r  = a_i & b_i;
  assign or_r   = a_i | b_i;
  assign xor_r  = a_i ^ b_i;

  always_comb begin
    case (op_i)
      OP_AND:    res_o = and_r;
      OP_OR:     res_o = or_r;
      OP_XOR:    res_o = xor_r;
      OP_ANDLSB: res_o = {{(XW-1){1'b0}}, and_r[0]};
      OP_ORLSB:  res_o = {{(XW-1){1'b0}}, or_r[0]};
      OP_XORLSB: res_o = {{(XW-1){1'b0}}, xor_r[0]};
      OP_ORH48:  res_o = {a_i[XW-1:8], 8'h00} | b_i;
      OP_CZEQZ:  res_o = b_zero ? '0 : a_i;
      OP_CZNEZ:  res_o = b_zero ? a_i : '0;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/fualu_top.sv
module fualu_top import fualu_pkg::*; #(
  parameter int XW = XLEN,
  parameter int WW = WLEN
) (
  input  logic [OPW-1:0] op_i,
  input  logic [XW-1:0]  src1_i,
  input  logic [XW-1:0]  src2_i,
  output logic [XW-1:0]  res_o
);
  localparam int SHW = $clog2(XW);

  logic [NGRP-1:0] grp_sel;
  logic            op_known;
  logic [XW-1:0]   unit_res [NGRP];

  assign grp_sel  = op_group(op_i);
  assign op_known = |grp_sel;

  fualu_add64 #(.XW(XW)) u_add64 (
    .op_i (op_i), .a_i (src1_i), .b_i (src2_i), .res_o (unit_res[GI_ADD])
  );

  fualu_addw #(.XW(XW), .WW(WW)) u_addw (
    .op_i (op_i), .a_i (src1_i[WW-1:0]), .b_i (src2_i[WW-1:0]),
    .res_o (unit_res[GI_ADDW])
  );

  fualu_shift #(.XW(XW), .WW(WW)) u_shift (
    .op_i (op_i), .a_i (src1_i), .sh_i (src2_i[SHW-1:0]),
    .res_o (unit_res[GI_SHF])
  );

  fualu_logic #(.XW(XW)) u_logic (
    .op_i (op_i), .a_i (src1_i), .b_i (src2_i), .res_o (unit_res[GI_LOG])
  );

  // AND-OR result select driven by the one-hot group.
  always_comb begin
    res_o = '0;
    for (int g = 0; g < NGRP; g++) begin
      res_o = res_o | (unit_res[g] & {XW{grp_sel[g]}});
    end
  end
endmodule

// File: rtl/fualu_checker.sv
module fualu_checker import fualu_pkg::*; #(
  parameter int XW = XLEN,
  parameter int WW = WLEN
) (
  input logic [OPW-1:0]  op_i,
  input logic [XW-1:0]   src1_i,
  input logic [XW-1:0]   src2_i,
  input logic [XW-1:0]   res_o,
  input logic [NGRP-1:0] grp_sel,
  input logic            op_known
);
  always_comb begin
    if (!$isunknown({op_i, src1_i, src2_i, res_o})) begin
      a_r1_group_onehot: assert ($onehot0(grp_sel));
      if (!op_known) begin
        a_r1_unknown_zero: assert (res_o == '0);
      end
      if (op_i == OP_CZEQZ && src2_i == '0) begin
        a_r5_czeqz_zero: assert (res_o == '0);
      end
      if (op_i == OP_CZNEZ && src2_i != '0) begin
        a_r5_cznez_zero: assert (res_o == '0);
      end
      if (op_i == OP_ADDW || op_i == OP_SUBW || op_i == OP_ODDADDW) begin
        a_r4_word_sext: assert (res_o[XW-1:WW] == {(XW-WW){res_o[WW-1]}});
      end
      if (op_i == OP_ADDWBIT || op_i == OP_ANDLSB || op_i == OP_ORLSB || op_i == OP_XORLSB) begin
        a_r12_lsb_only: assert (res_o[XW-1:1] == '0);
      end
      if (op_i == OP_BYTE2 || op_i == OP_ADDWBYTE) begin
        a_r9_byte_only: assert (res_o[XW-1:8] == '0);
      end
      if (op_i == OP_SZEWL1) begin
        a_r8_szewl_low: assert (res_o[0] == 1'b0 && res_o[XW-1:WW+1] == '0);
      end
    end
  end
endmodule

bind fualu_top fualu_checker #(.XW(XW), .WW(WW)) u_chk (
  .op_i (op_i), .src1_i (src1_i), .src2_i (src2_i), .res_o (res_o),
  .grp_sel (grp_sel), .op_known (op_known)
);

// File: tb/fualu_top_test.sv
module fualu_top_test;
  logic        clk = 1'b0;
  logic [6:0]  op;
  logic [63:0] s1;
  logic [63:0] s2;
  logic [63:0] res;
  int          n_chk  = 0;
  int          n_fail = 0;
  int          cycles = 0;
  bit          done   = 0;

  always #5 clk = ~clk;

  fualu_top uut (.op_i(op), .src1_i(s1), .src2_i(s2), .res_o(res));

  function automatic logic [63:0] w2x(input logic [31:0] w);
    longint v;
    v = longint'(int'(w));
    return 64'(v);
  endfunction

  function automatic logic [63:0] model(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] lw;
    case (c)
      7'h00: return a + b;
      7'h01: return a - b;
      7'h02: return (longint'(a) < longint'(b)) ? 64'd1 : 64'd0;
      7'h03: return (a < b) ? 64'd1 : 64'd0;
      7'h04: return a & b;
      7'h05: return a | b;
      7'h06: return a ^ b;
      7'h07: return a << b[5:0];
      7'h08: return a >> b[5:0];
      7'h09: return 64'(longint'(a) >>> b[5:0]);
      7'h10: return a * 64'd16 + b;
      7'h11: return (a >> 29) + b;
      7'h12: return (a >> 30) + b;
      7'h13: return (a >> 31) + b;
      7'h14: return (a >> 32) + b;
      7'h15: return {63'd0, a[0]} + b;
      7'h18: return {32'd0, a[31:0]} * 64'd2;
      7'h19: return {32'd0, a[31:0]} * 64'd4;
      7'h1A: return {32'd0, a[31:0]} * 64'd8;
      7'h1B: return (a >> 8) & 64'hFF;
      7'h20: return (a & ~64'hFF) | b;
      7'h21: return {63'd0, a[0] & b[0]};
      7'h22: return {63'd0, a[0] | b[0]};
      7'h23: return {63'd0, a[0] ^ b[0]};
      7'h24: return (b == 64'd0) ? 64'd0 : a;
      7'h25: return (b != 64'd0) ? 64'd0 : a;
      7'h40: begin lw = a[31:0] + b[31:0]; return w2x(lw); end
      7'h41: begin lw = a[31:0] - b[31:0]; return w2x(lw); end
      7'h42: begin lw = a[31:0] << b[4:0]; return w2x(lw); end
      7'h43: begin lw = a[31:0] >> b[4:0]; return w2x(lw); end
      7'h44: begin lw = 32'(int'(a[31:0]) >>> b[4:0]); return w2x(lw); end
      7'h45: begin lw = {31'd0, a[0]} + b[31:0]; return w2x(lw); end
      7'h46: begin lw = a[31:0] + b[31:0]; return w2x(lw) & 64'hFF; end
      7'h47: begin lw = a[31:0] + b[31:0]; return w2x(lw) & 64'h1; end
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [6:0] c);
    if (c <= 7'h06) return "R2";
    if (c <= 7'h09 || (c >= 7'h42 && c <= 7'h44)) return "R3";
    if (c == 7'h40 || c == 7'h41) return "R4";
    if (c == 7'h24 || c == 7'h25) return "R5";
    if (c >= 7'h10 && c <= 7'h14) return "R6";
    if (c == 7'h15 || c == 7'h45) return "R7";
    if (c >= 7'h18 && c <= 7'h1A) return "R8";
    if (c == 7'h1B) return "R9";
    if (c == 7'h20) return "R10";
    if (c == 7'h46 || c == 7'h47) return "R11";
    if (c >= 7'h21 && c <= 7'h23) return "R12";
    return "R1";
  endfunction

  function automatic logic [63:0] corner(input int i);
    case (i)
      0: return 64'd0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h0000_0000_8000_0000;
      3: return 64'h0000_0000_7FFF_FFFF;
      default: return 64'd1;
    endcase
  endfunction

  task automatic apply(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] exp_v;
    @(posedge clk);
    op = c; s1 = a; s2 = b;
    exp_v = model(c, a, b);
    @(negedge clk);
    n_chk++;
    if (res !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%02h a=%016h b=%016h actual=%016h expected=%016h",
               tag_of(c), c, a, b, res, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    op = '0; s1 = '0; s2 = '0;
    // Idle state: all-zero inputs must give zero (R2, ADD of zeros).
    apply(7'h00, 64'd0, 64'd0);
    // R5 directed: conditional zero on both sides of operand 2.
    apply(7'h24, 64'h1234, 64'd0);
    apply(7'h24, 64'h1234, 64'd7);
    apply(7'h25, 64'h1234, 64'd0);
    apply(7'h25, 64'h1234, 64'd7);
    // R11 directed: word sum with carry into bit 31 then masked.
    apply(7'h46, 64'h7FFF_FFFF, 64'h1);
    apply(7'h47, 64'h7FFF_FFFF, 64'h2);
    // Sweep every code (R1 for unlisted ones) with corner and random operands.
    for (int c = 0; c < 128; c++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          apply(7'(c), corner(i), corner(j));
        end
      end
      for (int r = 0; r < 12; r++) begin
        apply(7'(c), {$urandom, $urandom}, {$urandom, $urandom});
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule